// File: doc/BRIEF.md
# Trigger Pulse Counter Bank

This block counts rising edges on a set of asynchronous trigger lines for a sequencer processor. Each channel brings its trigger through a two-flop synchroniser and an edge detector, then feeds a live counter that saturates instead of wrapping. Each channel also holds a snapshot register and a threshold register. The processor issues counting commands over a valid/ready command stream. There are five commands: clear a live counter, snapshot it, store a snapshot to memory, test a snapshot against its threshold, and take a branch on the result of the test.

A store command raises the fetch stall output. It then presents a 32-bit write request on a valid/ready memory port, at the address held in an address accumulator. When the memory accepts the request, the accumulator steps by one and the stall drops. A one-cycle resume pulse then returns the program address that came with the store command, so fetch restarts where it stopped. Software can load the accumulator through a separate strobe. The threshold registers are written through a plain load port.

Back-pressure rules are as follows. A command is taken on a clock edge where `op_valid` and `op_ready` are both high. The sender must hold the command steady while `op_ready` is low. `op_ready` stays low for as long as a store is outstanding. A memory request stays valid, with its address and data steady, until the edge where `mem_ready` is high.

Top module: `trig_count_bank`

## Requirements
- R1: A rising edge on `trig_in[c]` adds one to live counter c. The new value is visible three clock edges after the trigger line is sampled high for the first time (two synchroniser flops and one edge flop). Channels count independently.
- R2: A live counter at all ones stays at all ones when further edges arrive.
- R3: Command code 0 (clear) sets the live counter of channel `op_chan` to zero. A clear wins over an edge counted on the same edge.
- R4: Command code 1 (snapshot) copies the live counter of channel `op_chan` into that channel's snapshot register. The value copied is the one held before that edge.
- R5: On a clock edge where `thr_we` is high, the threshold register of channel `thr_sel` takes `thr_data`.
- R6: Command code 3 (test) sets `cmp_flag` to 1 when snapshot >= threshold of channel `op_chan`, and to 0 otherwise. The flag keeps its value until the next test, and it is 0 after reset.
- R7: Command code 4 (branch) raises `branch_take` for the one cycle after it is taken, if `cmp_flag` was 1. It leaves `cmp_flag` unchanged.
- R8: Command code 2 (store) raises `mem_valid` in the next cycle, with `mem_data` set to the zero-extended snapshot of `op_chan` and `mem_addr` set to the accumulator. Address and data stay steady until `mem_ready`. On the handshake the accumulator increases by one. It is 0 after reset.
- R9: `fetch_stall` is high and `op_ready` is low from the cycle after a store is taken until the cycle after its memory handshake. A command held during that time has no effect until it is accepted.
- R10: In the cycle after a memory handshake, `resume_pulse` is high for one cycle and `resume_pc` equals the `op_pc` that came with the store.
- R11: On a clock edge where `acc_load` is high, the accumulator takes `acc_value`. A load wins over the increment from a handshake on the same edge.
- R12: Command codes 5, 6 and 7 change no counter, snapshot, flag or accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | NCH | Asynchronous trigger lines |
| op_valid | input | 1 | Command valid |
| op_ready | output | 1 | Command may be taken |
| op_code | input | 3 | Command code: 0 clear, 1 snapshot, 2 store, 3 test, 4 branch |
| op_chan | input | CHW | Channel selected by the command |
| op_pc | input | PCW | Program address of the command |
| thr_we | input | 1 | Threshold load strobe |
| thr_sel | input | CHW | Channel whose threshold is loaded |
| thr_data | input | CW | Threshold value |
| acc_load | input | 1 | Accumulator load strobe |
| acc_value | input | AW | Accumulator load value |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | AW | Write address (accumulator) |
| mem_data | output | DW | Write data |
| fetch_stall | output | 1 | Holds instruction fetch |
| resume_pulse | output | 1 | Fetch may restart |
| resume_pc | output | PCW | Address at which fetch restarts |
| cmp_flag | output | 1 | Result of the last test |
| branch_take | output | 1 | Branch decision pulse |

## Verification
A trigger edge reaches its live counter three edges after it is first sampled. A command result is due one edge after the command is taken: the snapshot, the flag, the branch pulse, the stall and the memory request. The resume pulse and the accumulator step are due one edge after the memory handshake. The bench drives inputs and samples outputs on the falling edge. Its reference model advances on each rising edge under these same latencies, so every output is compared in the cycle it is due. Counts only show at the ports through a snapshot followed by a store, so the directed checks read them from the memory request while `mem_ready` is held low for several cycles.

// File: rtl/trigcnt_pkg.sv
package trigcnt_pkg;
  typedef enum logic [2:0] {
    OP_CLR    = 3'd0,
    OP_SNAP   = 3'd1,
    OP_STORE  = 3'd2,
    OP_TEST   = 3'd3,
    OP_BRANCH = 3'd4
  } cnt_op_e;
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int NCH    = 8,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] trig_i,
  output logic [NCH-1:0] rise_o
);
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_lane
      logic [STAGES:0] sr;
      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-1:0], trig_i[g]};
      end
      assign rise_o[g] = sr[STAGES-1] & ~sr[STAGES];
    end
  endgenerate
endmodule

// File: rtl/chan_counter.sv
module chan_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          clr_i,
  input  logic          snap_i,
  input  logic          thr_we_i,
  input  logic [CW-1:0] thr_d_i,
  output logic [CW-1:0] snap_o,
  output logic [CW-1:0] thr_o
);
  localparam logic [CW-1:0] CMAX = '1;
  logic [CW-1:0] live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= '0;
      snap_o <= '0;
      thr_o  <= '0;
    end else begin
      if (clr_i)                      live <= '0;
      else if (rise_i && live != CMAX) live <= live + 1'b1;
      if (snap_i)   snap_o <= live;
      if (thr_we_i) thr_o  <= thr_d_i;
    end
  end

  assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live == CMAX && !clr_i) |=> live == CMAX);
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> live == '0);
  assert_snap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> snap_o == $past(live));
endmodule

// File: rtl/mem_write_ctl.sv
module mem_write_ctl #(
  parameter int DW  = 32,
  parameter int AW  = 16,
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           store_i,
  input  logic [DW-1:0]  data_i,
  input  logic [PCW-1:0] pc_i,
  input  logic           acc_load_i,
  input  logic [AW-1:0]  acc_val_i,
  input  logic           mem_ready_i,
  output logic           mem_valid_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_data_o,
  output logic           resume_o,
  output logic [PCW-1:0] resume_pc_o
);
  logic hs;
  assign hs = mem_valid_o & mem_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid_o <= 1'b0;
      mem_addr_o  <= '0;
      mem_data_o  <= '0;
      resume_o    <= 1'b0;
      resume_pc_o <= '0;
    end else begin
      resume_o <= hs;
      if (acc_load_i) mem_addr_o <= acc_val_i;
      else if (hs)    mem_addr_o <= mem_addr_o + 1'b1;
      if (hs) mem_valid_o <= 1'b0;
      else if (store_i) begin
        mem_valid_o <= 1'b1;
        mem_data_o  <= data_i;
        resume_pc_o <= pc_i;
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> mem_valid_o && $stable(mem_data_o));
  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !acc_load_i) |=> mem_addr_o == AW'($past(mem_addr_o) + 1'b1));
  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_load_i |=> mem_addr_o == $past(acc_val_i));
  assert_resume_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> resume_o && !mem_valid_o);
endmodule

// File: rtl/trig_count_bank.sv
module trig_count_bank
  import trigcnt_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 32,
  parameter int DW  = 32,
  parameter int AW  = 16,
  parameter int PCW = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] trig_in,
  input  logic           op_valid,
  output logic           op_ready,
  input  logic [2:0]     op_code,
  input  logic [CHW-1:0] op_chan,
  input  logic [PCW-1:0] op_pc,
  input  logic           thr_we,
  input  logic [CHW-1:0] thr_sel,
  input  logic [CW-1:0]  thr_data,
  input  logic           acc_load,
  input  logic [AW-1:0]  acc_value,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_data,
  output logic           fetch_stall,
  output logic           resume_pulse,
  output logic [PCW-1:0] resume_pc,
  output logic           cmp_flag,
  output logic           branch_take
);
  logic [NCH-1:0] rise;
  logic [CW-1:0]  snap [NCH];
  logic [CW-1:0]  thr  [NCH];
  logic           take, is_clr, is_snap, is_store, is_test, is_br;

  assign op_ready    = ~mem_valid;
  assign fetch_stall = mem_valid;
  assign take        = op_valid & op_ready;
  assign is_clr      = take && op_code == OP_CLR;
  assign is_snap     = take && op_code == OP_SNAP;
  assign is_store    = take && op_code == OP_STORE;
  assign is_test     = take && op_code == OP_TEST;
  assign is_br       = take && op_code == OP_BRANCH;

  trig_sync_edge #(.NCH(NCH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_in), .rise_o(rise)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chan
      chan_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .rise_i(rise[g]),
        .clr_i(is_clr && op_chan == CHW'(g)),
        .snap_i(is_snap && op_chan == CHW'(g)),
        .thr_we_i(thr_we && thr_sel == CHW'(g)),
        .thr_d_i(thr_data), .snap_o(snap[g]), .thr_o(thr[g])
      );
    end
  endgenerate

  mem_write_ctl #(.DW(DW), .AW(AW), .PCW(PCW)) u_wr (
    .clk(clk), .rst_n(rst_n), .store_i(is_store),
    .data_i(DW'(snap[op_chan])), .pc_i(op_pc),
    .acc_load_i(acc_load), .acc_val_i(acc_value), .mem_ready_i(mem_ready),
    .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .resume_o(resume_pulse), .resume_pc_o(resume_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_flag    <= 1'b0;
      branch_take <= 1'b0;
    end else begin
      if (is_test) cmp_flag <= (snap[op_chan] >= thr[op_chan]);
      branch_take <= is_br & cmp_flag;
    end
  end

  assert_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    branch_take |-> $past(cmp_flag) && $stable(cmp_flag));
  assert_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && fetch_stall) |=> $stable(cmp_flag) && !branch_take);
  assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_test |=> $stable(cmp_flag));
endmodule

// File: tb/trig_count_bank_tb.sv
module trig_count_bank_tb;
  localparam int NCH = 8, CW = 4, DW = 32, AW = 8, PCW = 8;
  localparam int CMAX = 15;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] trig_in = '0;
  logic op_valid = 0, op_ready;
  logic [2:0] op_code = '0;
  logic [2:0] op_chan = '0;
  logic [PCW-1:0] op_pc = '0;
  logic thr_we = 0;
  logic [2:0] thr_sel = '0;
  logic [CW-1:0] thr_data = '0;
  logic acc_load = 0;
  logic [AW-1:0] acc_value = '0;
  logic mem_valid, mem_ready = 0, fetch_stall, resume_pulse, cmp_flag, branch_take;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [PCW-1:0] resume_pc;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trig_count_bank #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW), .PCW(PCW)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .op_valid(op_valid),
    .op_ready(op_ready), .op_code(op_code), .op_chan(op_chan), .op_pc(op_pc),
    .thr_we(thr_we), .thr_sel(thr_sel), .thr_data(thr_data),
    .acc_load(acc_load), .acc_value(acc_value), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .fetch_stall(fetch_stall), .resume_pulse(resume_pulse),
    .resume_pc(resume_pc), .cmp_flag(cmp_flag), .branch_take(branch_take)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_s1 [NCH], m_s2 [NCH], m_pv [NCH];
  int m_cnt [NCH], m_snap [NCH], m_thr [NCH];
  int m_acc, m_data, m_pc;
  bit m_busy, m_flag, m_take, m_res;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) begin
        m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0;
        m_cnt[i] = 0; m_snap[i] = 0; m_thr[i] = 0;
      end
      m_acc = 0; m_data = 0; m_pc = 0;
      m_busy = 0; m_flag = 0; m_take = 0; m_res = 0;
    end else begin
      bit ok;
      int o_snap [NCH], o_thr [NCH];
      bit o_flag, o_busy;
      o_snap = m_snap; o_thr = m_thr; o_flag = m_flag; o_busy = m_busy;
      ok = op_valid && !o_busy;
      for (int i = 0; i < NCH; i++) begin
        bit edge_seen;
        edge_seen = m_s2[i] && !m_pv[i];
        if (ok && op_code == 1 && op_chan == i) m_snap[i] = m_cnt[i];
        if (ok && op_code == 0 && op_chan == i) m_cnt[i] = 0;
        else if (edge_seen && m_cnt[i] < CMAX) m_cnt[i]++;
        if (thr_we && thr_sel == i) m_thr[i] = thr_data;
        m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = trig_in[i];
      end
      if (ok && op_code == 3) m_flag = o_snap[op_chan] >= o_thr[op_chan];
      m_take = ok && op_code == 4 && o_flag;
      m_res = 0;
      if (o_busy && mem_ready) begin
        m_busy = 0; m_res = 1;
        m_acc = (m_acc + 1) % 256;
      end
      if (acc_load) m_acc = acc_value;
      if (ok && op_code == 2) begin
        m_busy = 1; m_data = o_snap[op_chan]; m_pc = op_pc;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 op_ready", op_ready, !m_busy);
      chk("R9 fetch_stall", fetch_stall, m_busy);
      chk("R8 mem_valid", mem_valid, m_busy);
      chk("R11 mem_addr", mem_addr, m_acc);
      if (m_busy) chk("R8 mem_data", mem_data, m_data);
      chk("R10 resume_pulse", resume_pulse, m_res);
      if (m_res) chk("R10 resume_pc", resume_pc, m_pc);
      chk("R6 cmp_flag", cmp_flag, m_flag);
      chk("R7 branch_take", branch_take, m_take);
    end
  end

  task automatic issue(input int code, input int ch, input int pc);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_valid = 1; op_code = 3'(code); op_chan = 3'(ch); op_pc = PCW'(pc);
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic pulses(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); trig_in[ch] = 1;
      @(negedge clk);
      @(negedge clk); trig_in[ch] = 0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic store(input int ch, input int pc, input int exp_addr,
                       input int exp_data, input string tag);
    issue(2, ch, pc);
    chk({tag, " store valid"}, mem_valid, 1);
    chk("R9 stall during store", fetch_stall, 1);
    chk({tag, " store addr"}, mem_addr, exp_addr);
    chk({tag, " store data"}, mem_data, exp_data);
    repeat (3) @(negedge clk);
    chk("R8 data held", mem_data, exp_data);
    chk("R9 ready low", op_ready, 0);
    mem_ready = 1;
    @(negedge clk);
    mem_ready = 0;
    chk("R10 resume", resume_pulse, 1);
    chk("R10 resume pc", resume_pc, pc);
    chk("R8 addr step", mem_addr, (exp_addr + 1) % 256);
    chk("R9 ready again", op_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset valid", mem_valid, 0);
    chk("R8 reset addr", mem_addr, 0);
    chk("R6 reset flag", cmp_flag, 0);
    chk("R9 reset ready", op_ready, 1);

    pulses(2, 3);
    issue(1, 2, 0);
    store(2, 8'h11, 0, 3, "R1");

    @(negedge clk); acc_load = 1; acc_value = 8'h40;
    @(negedge clk); acc_load = 0;
    chk("R11 loaded", mem_addr, 8'h40);
    store(2, 8'h22, 8'h40, 3, "R11");

    pulses(5, 20);
    issue(1, 5, 0);
    store(5, 8'h33, 8'h41, CMAX, "R2");

    issue(0, 5, 0);
    issue(1, 5, 0);
    store(5, 8'h44, 8'h42, 0, "R3");

    @(negedge clk); thr_we = 1; thr_sel = 2; thr_data = 3;
    @(negedge clk); thr_we = 0;
    issue(3, 2, 0);
    chk("R5 R6 ge flag", cmp_flag, 1);
    issue(4, 2, 0);
    chk("R7 taken", branch_take, 1);
    chk("R7 flag kept", cmp_flag, 1);
    @(negedge clk); thr_we = 1; thr_data = 4;
    @(negedge clk); thr_we = 0;
    issue(3, 2, 0);
    chk("R6 lt flag", cmp_flag, 0);
    issue(4, 2, 0);
    chk("R7 not taken", branch_take, 0);

    pulses(2, 1);
    issue(6, 2, 0);
    issue(5, 2, 0);
    chk("R12 flag kept", cmp_flag, 0);
    store(2, 8'h55, 8'h43, 3, "R12");
    issue(1, 2, 0);
    store(2, 8'h66, 8'h44, 4, "R4");

    // R9: a clear held during a stall takes effect only once accepted
    issue(2, 2, 8'h77);
    op_valid = 1; op_code = 3'd0; op_chan = 3'd2;
    repeat (2) @(negedge clk);
    mem_ready = 1;
    @(negedge clk); mem_ready = 0;
    @(negedge clk); op_valid = 0;
    issue(1, 2, 0);
    store(2, 8'h78, 8'h46, 0, "R9");

    repeat (5) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule